// File: doc/BRIEF.md
# UART Interrupt Status and Routing

This block holds the eleven raw interrupt status bits of a UART and turns them into six interrupt request lines. Event sources in the receive path, transmit path, receive-timeout logic, modem-status inputs and line-error detection drive one set input per status bit. A set input may be a one-cycle pulse or a held level. A set bit stays latched until software clears it. A software-written enable vector masks the raw status. The masked result drives one combined request line and five group lines.

Software reaches the block through a 32-bit register port with four word addresses. The enable vector is read-write. Raw status and masked status are read-only. A clear location takes a write-one-to-clear vector and reads as zero. All six request lines are registered. Each line follows the masked status one clock later, whether the change came from an event, a clear or an enable write.

Top module: `uart_irq_router`

## Requirements
- R1: After reset the enable vector, the raw status and all six request lines are zero.
- R2: A 1 on set input bit i makes raw status bit i read as 1 from the next clock on (address 1). It stays set with no further set input until a clear removes it.
- R3: A write to address 3 clears each raw bit whose written bit is 1 and leaves every other raw bit unchanged.
- R4: If a set input and a clear write hit the same bit in the same cycle, the bit ends up set.
- R5: A write to address 0 stores written bits 10..0 as the enable vector. Address 0 reads it back, and address 2 reads raw status AND enable.
- R6: Line 0 is 1 exactly when any masked bit was 1 in the previous cycle.
- R7: Line 1 follows masked bit 4 (receive), line 2 masked bit 5 (transmit) and line 3 masked bit 6 (receive timeout), each delayed by one clock.
- R8: Line 4 is the OR of masked bits 3..0 (modem status: RI bit 0, CTS bit 1, DCD bit 2, DSR bit 3). Line 5 is the OR of masked bits 10..7 (framing 7, parity 8, break 9, overrun 10). Both are delayed by one clock.
- R9: A change of the enable vector alone reaches the request lines one clock after the enable register changes, with no new event needed.
- R10: Read bits 31..11 are always zero, and written bits 31..11 are ignored. Address 3 reads zero. Writes to addresses 1 and 2 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_set_i | input | 11 | Per-bit status set inputs, same layout as the status vector |
| acc_we_i | input | 1 | Register write strobe |
| acc_addr_i | input | 2 | Word address: 0 enable, 1 raw, 2 masked, 3 clear |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Read data for the addressed word, combinational |
| irq_o | output | 6 | Request lines: 0 combined, 1 receive, 2 transmit, 3 timeout, 4 modem, 5 error |

## Verification
A wrong latched status bit shows at the raw and masked reads on the next cycle. If that bit is enabled, it also reaches the combined line and its group line one clock after that. A lost enable bit or a wrong grouping of bits shows only as a wrong request line one clock after the masked vector changes. The bench therefore compares all six lines and the addressed read word with a behavioural model on every cycle. Random event, clear and enable traffic runs alongside directed cases for collisions and enable-only changes.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int unsigned IRQ_BITS  = 11;
   localparam int unsigned NUM_LINES = 6;
   localparam int unsigned ADDR_W    = 2;

   // status bit positions (layout decoded by software)
   localparam int unsigned B_RI   = 0;
   localparam int unsigned B_CTS  = 1;
   localparam int unsigned B_DCD  = 2;
   localparam int unsigned B_DSR  = 3;
   localparam int unsigned B_RX   = 4;
   localparam int unsigned B_TX   = 5;
   localparam int unsigned B_TMO  = 6;
   localparam int unsigned B_FRM  = 7;
   localparam int unsigned B_PAR  = 8;
   localparam int unsigned B_BRK  = 9;
   localparam int unsigned B_OVR  = 10;

   typedef logic [IRQ_BITS-1:0] irq_vec_t;

   typedef enum logic [ADDR_W-1:0] {
      REG_ENABLE = 2'd0,
      REG_RAW    = 2'd1,
      REG_MASKED = 2'd2,
      REG_CLEAR  = 2'd3
   } reg_addr_e;

   // which status bits feed request line idx
   function automatic irq_vec_t line_mask(input int unsigned idx);
      irq_vec_t m;
      m = '0;
      case (idx)
         0: m = '1;
         1: m[B_RX]  = 1'b1;
         2: m[B_TX]  = 1'b1;
         3: m[B_TMO] = 1'b1;
         4: begin
            m[B_RI] = 1'b1; m[B_CTS] = 1'b1; m[B_DCD] = 1'b1; m[B_DSR] = 1'b1;
         end
         5: begin
            m[B_FRM] = 1'b1; m[B_PAR] = 1'b1; m[B_BRK] = 1'b1; m[B_OVR] = 1'b1;
         end
         default: m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status
   import uart_irq_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  irq_vec_t set_i,
   input  logic     clr_we_i,
   input  irq_vec_t clr_vec_i,
   output irq_vec_t raw_o
);

   irq_vec_t raw_q;
   irq_vec_t clr_eff;

   assign clr_eff = clr_we_i ? clr_vec_i : '0;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) raw_q <= '0;
      else         raw_q <= (raw_q & ~clr_eff) | set_i;
   end

   assign raw_o = raw_q;

   // R2
   raw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_we_i && set_i == '0) |=> $stable(raw_q));

   // R3
   clear_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_we_i |=> ((raw_q & $past(clr_vec_i & ~set_i)) == '0));

   // R4
   set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i != '0) |=> ((raw_q & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
   import uart_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 32
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              acc_we_i,
   input  logic [ADDR_W-1:0] acc_addr_i,
   input  logic [DATA_W-1:0] acc_wdata_i,
   input  irq_vec_t          raw_i,
   output irq_vec_t          en_o,
   output logic              clr_we_o,
   output irq_vec_t          clr_vec_o,
   output logic [DATA_W-1:0] acc_rdata_o
);

   localparam int unsigned PAD_W = DATA_W - IRQ_BITS;

   generate
      if (DATA_W <= IRQ_BITS) begin : g_bad_width
         $error("uart_irq_regs: DATA_W must exceed the status width");
      end
   endgenerate

   irq_vec_t en_q;
   irq_vec_t wvec;
   irq_vec_t rd_vec;
   logic     unused_hi;

   assign wvec      = acc_wdata_i[IRQ_BITS-1:0];
   assign unused_hi = ^acc_wdata_i[DATA_W-1:IRQ_BITS];

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         en_q <= '0;
      else if (acc_we_i && acc_addr_i == REG_ENABLE)
         en_q <= wvec;
   end

   assign clr_we_o  = acc_we_i && (acc_addr_i == REG_CLEAR);
   assign clr_vec_o = wvec;
   assign en_o      = en_q;

   always_comb begin
      case (reg_addr_e'(acc_addr_i))
         REG_ENABLE: rd_vec = en_q;
         REG_RAW:    rd_vec = raw_i;
         REG_MASKED: rd_vec = raw_i & en_q;
         default:    rd_vec = '0;
      endcase
   end

   assign acc_rdata_o = {{PAD_W{1'b0}}, rd_vec};

   // R5
   enable_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_we_i && acc_addr_i == REG_ENABLE) |=> (en_q == $past(wvec)));

   // R10
   enable_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(acc_we_i && acc_addr_i == REG_ENABLE) |=> $stable(en_q));

endmodule

// File: rtl/uart_irq_route.sv
module uart_irq_route
   import uart_irq_pkg::*;
#(
   parameter int unsigned LINES = NUM_LINES
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  irq_vec_t         masked_i,
   output logic [LINES-1:0] irq_o
);

   generate
      if (LINES != NUM_LINES) begin : g_bad_lines
         $error("uart_irq_route: LINES must equal the defined line count");
      end
   endgenerate

   logic [LINES-1:0] irq_q;

   for (genvar l = 0; l < LINES; l++) begin : g_line
      localparam irq_vec_t SEL = line_mask(l);
      always_ff @(posedge clk_i) begin
         if (!rst_ni) irq_q[l] <= 1'b0;
         else         irq_q[l] <= |(masked_i & SEL);
      end
   end

   assign irq_o = irq_q;

   // R6
   combined_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (irq_q[0] == ($past(masked_i) != '0)));

   // R8
   error_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (irq_q[5] == ($past(masked_i[B_OVR:B_FRM]) != 4'd0)));

   // R8
   modem_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (irq_q[4] == ($past(masked_i[B_DSR:B_RI]) != 4'd0)));

endmodule

// File: rtl/uart_irq_router.sv
module uart_irq_router
   import uart_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 32
)(
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [IRQ_BITS-1:0]  evt_set_i,
   input  logic                 acc_we_i,
   input  logic [ADDR_W-1:0]    acc_addr_i,
   input  logic [DATA_W-1:0]    acc_wdata_i,
   output logic [DATA_W-1:0]    acc_rdata_o,
   output logic [NUM_LINES-1:0] irq_o
);

   irq_vec_t raw;
   irq_vec_t en;
   irq_vec_t clr_vec;
   logic     clr_we;

   uart_irq_regs #(.DATA_W(DATA_W)) i_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .acc_we_i    (acc_we_i),
      .acc_addr_i  (acc_addr_i),
      .acc_wdata_i (acc_wdata_i),
      .raw_i       (raw),
      .en_o        (en),
      .clr_we_o    (clr_we),
      .clr_vec_o   (clr_vec),
      .acc_rdata_o (acc_rdata_o)
   );

   uart_irq_status i_status (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (evt_set_i),
      .clr_we_i  (clr_we),
      .clr_vec_i (clr_vec),
      .raw_o     (raw)
   );

   uart_irq_route #(.LINES(NUM_LINES)) i_route (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .masked_i (raw & en),
      .irq_o    (irq_o)
   );

   // R7
   rx_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (irq_o[1] == $past(raw[B_RX] & en[B_RX])));

endmodule

// File: tb/test_uart_irq_router.sv
module test_uart_irq_router;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] evt_set = '0;
   logic        we = 1'b0;
   logic [1:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [5:0]  irq;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   bit          done = 0;

   // model state
   int unsigned m_raw = 0;
   int unsigned m_en  = 0;
   int unsigned m_irq = 0;

   always #4 clk = ~clk;

   uart_irq_router i_uart_irq_router (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .evt_set_i   (evt_set),
      .acc_we_i    (we),
      .acc_addr_i  (addr),
      .acc_wdata_i (wdata),
      .acc_rdata_o (rdata),
      .irq_o       (irq)
   );

   function automatic int unsigned lines_of(input int unsigned mk);
      int unsigned r;
      r = 0;
      if (mk != 0)               r |= 1;
      if (mk & 32'h10)           r |= 2;
      if (mk & 32'h20)           r |= 4;
      if (mk & 32'h40)           r |= 8;
      if (mk & 32'h00F)          r |= 16;
      if (mk & 32'h780)          r |= 32;
      return r;
   endfunction

   function automatic int unsigned read_of(input int unsigned a);
      case (a)
         0: return m_en;
         1: return m_raw;
         2: return m_raw & m_en;
         default: return 0;
      endcase
   endfunction

   task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // one clock: drive, model update after edge, compare at falling edge
   task automatic cyc(input int unsigned s, input bit w, input int unsigned a,
                      input int unsigned d);
      evt_set = s[10:0];
      we      = w;
      addr    = a[1:0];
      wdata   = d;
      @(posedge clk);
      #1;
      if (!rst_n) begin
         m_raw = 0; m_en = 0; m_irq = 0;
      end else begin
         m_irq = lines_of(m_raw & m_en);
         m_raw = (m_raw & ~((w && a == 3) ? (d & 32'h7FF) : 0)) | s;
         if (w && a == 0) m_en = d & 32'h7FF;
      end
      @(negedge clk);
      chk("R6 R7 R8 request lines", irq, m_irq);
      case (a)
         0: chk("R5 enable read", rdata, read_of(a));
         1: chk("R2 raw read", rdata, read_of(a));
         2: chk("R5 masked read", rdata, read_of(a));
         default: chk("R10 clear reads zero", rdata, read_of(a));
      endcase
   endtask

   initial begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);
      rst_n = 1'b1;
      // R1 reset state
      cyc(0, 0, 0, 0); chk("R1 enable at reset", rdata, 0);
      cyc(0, 0, 1, 0); chk("R1 raw at reset", rdata, 0);
      chk("R1 lines at reset", irq, 0);

      // R2 events latch while masked off; lines stay low
      cyc(32'h010, 0, 1, 0);
      cyc(0, 0, 1, 0); chk("R2 rx bit held", rdata, 32'h010);
      cyc(0, 0, 1, 0); chk("R2 masked off no line", irq, 0);

      // R9 enable only, upper bits ignored (R10)
      cyc(0, 1, 0, 32'hFFFF_F010);
      chk("R10 upper enable bits dropped", rdata, 32'h010);
      chk("R9 line not yet up", irq, 0);
      cyc(0, 0, 2, 0); chk("R9 lines after enable", irq, 32'h03);

      // R8 each group
      cyc(0, 1, 0, 32'h7FF);
      cyc(32'h004, 0, 2, 0);
      cyc(0, 0, 2, 0);
      chk("R8 modem group", irq & 6'h10, 6'h10);
      cyc(32'h200, 1, 3, 32'h014);
      cyc(0, 0, 2, 0);
      chk("R3 masked after clear", rdata, 32'h200);
      cyc(0, 0, 2, 0);
      chk("R8 error group only", irq, 6'h21);

      // R4 set and clear same bit
      cyc(32'h020, 1, 3, 32'h7FF);
      cyc(0, 0, 1, 0); chk("R4 set wins", rdata, 32'h020);
      chk("R7 transmit line", irq & 6'h04, 6'h04);

      // R10 writes to raw and masked locations ignored
      cyc(0, 1, 1, 0);
      cyc(0, 1, 2, 0);
      cyc(0, 0, 1, 0); chk("R10 raw write ignored", rdata, 32'h020);

      // random traffic
      for (int k = 0; k < 600; k++) begin
         int unsigned s, a, d, w;
         s = (($urandom % 4) == 0) ? ($urandom & 32'h7FF) : 0;
         w = $urandom % 3 == 0;
         a = $urandom % 4;
         d = $urandom;
         cyc(s, w[0], a, d);
      end
      done = 1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (50000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule